// File: doc/BRIEF.md
# Streaming Histogram Bin Accumulator

This block counts how often each bin index occurs in a stream of already-binned samples. The counters live in a simple dual-port RAM. The RAM has one write port and one read port, and read data appears one clock after the read address is presented. The block still accepts one sample on every clock.

A register holds the bin of the most recent sample together with that bin's running count. While the incoming bin stays the same, only this register is incremented. When the bin changes, the held count is written back to its address on the write port. In the same cycle, the new bin's stored count is fetched on the read port. Because the fetched value arrives one cycle late, it is folded into the held count in the next cycle.

A frame starts with a clear pulse, which zeroes every counter in one pass of NBINS cycles. Samples are then streamed in with a valid/ready handshake, and the final sample is tagged with a last flag. The block writes back the held count and then pulses done. After done, the counters can be read one per cycle through a readout port.

Top module: `hist_accum`

## Requirements
- R1: While reset is high and in the cycle after it falls, in_ready and done are both 0.
- R2: A one-cycle pulse on clr_start zeroes all NBINS counters. in_ready rises exactly NBINS clock edges after the edge that samples the pulse.
- R3: At the end of a frame, the counter at each bin index equals the number of samples of that bin accepted in the frame.
- R4: A run of consecutive accepted samples with the same bin performs no RAM write, and each sample of the run adds one to the held count.
- R5: In any cycle where a sample is accepted and a count is written back, the write address differs from the read address.
- R6: During a frame, in_ready stays high on every cycle until the sample flagged last is accepted. This gives one sample per clock with back-to-back valid.
- R7: A bin that comes back after one different bin (pattern a, b, a) counts all of its samples.
- R8: A sample of a bin that arrives in the cycle right after that bin was fetched adds to the fetched count. The same holds for a sample that arrives after idle cycles.
- R9: done is high for exactly one cycle, two clock edges after the edge that accepts the last sample. By then the held count has been written back.
- R10: Counters are CNT_W bits wide and wrap modulo 2^CNT_W.
- R11: While idle, rd_data shows the counter at rd_addr one clock edge after rd_addr is applied.
- R12: in_valid is ignored while in_ready is low. Samples offered when no frame is open leave the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_start | input | 1 | Pulse: clear all counters and open a new frame |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_bin | input | BIN_W | Bin index of the sample |
| in_last | input | 1 | Sample is the last one of the frame |
| done | output | 1 | One-cycle pulse once all counts are in RAM |
| rd_addr | input | BIN_W | Readout bin index |
| rd_data | output | CNT_W | Counter at the readout index, one cycle later |

## Verification
The in-RTL properties check these rules on every cycle:
- the write and read addresses never coincide while a sample is being taken;
- a repeated bin never writes the RAM, and the held count steps by one;
- the handshake stays open until last is accepted;
- the clear keeps the input closed;
- done follows the last sample by two edges and lasts one cycle.

Only the bench scenarios can show that the final counts are right. Those scenarios cover runs, the a-b-a revisit, a repeat straight after a fetch, idle gaps, wrap-around, and samples offered while no frame is open.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2,
    ST_FLUSH = 2'd3
  } hist_state_t;
endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hist_seq.sv
module hist_seq
  import hist_pkg::*;
#(
  parameter int NBINS = 256,
  localparam int AW   = $clog2(NBINS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_start,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic          clr_we,
  output logic [AW-1:0] clr_addr,
  output logic          flush,
  output logic          done,
  output hist_state_t   state
);
  logic [AW-1:0] idx;
  logic          take_last;

  assign in_ready  = (state == ST_RUN);
  assign take_last = in_valid && in_ready && in_last;
  assign clr_we    = (state == ST_CLEAR);
  assign clr_addr  = idx;
  assign flush     = (state == ST_FLUSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr_start) begin
        state <= ST_CLEAR;
        idx   <= '0;
      end else begin
        case (state)
          ST_CLEAR: begin
            idx <= idx + 1'b1;
            if (idx == AW'(NBINS - 1)) state <= ST_RUN;
          end
          ST_RUN:   if (take_last) state <= ST_FLUSH;
          ST_FLUSH: begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  // R6: input stays open until the last sample is taken
  a_r6_ready_held: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !take_last && !clr_start) |=> in_ready);
  // R2: no sample accepted while counters are being cleared
  a_r2_clear_closed: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLEAR) |-> !in_ready);
  // R9: done comes two edges after the last sample
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(take_last, 2));
  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/hist_acc.sv
module hist_acc #(
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          take,
  input  logic [AW-1:0] bin,
  input  logic          flush,
  input  logic [CW-1:0] ram_q,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] wr_data
);
  logic [AW-1:0] cur_bin;
  logic [CW-1:0] acc;
  logic          pend;
  logic          have;
  logic [CW-1:0] eff;
  logic          same;

  // fold the late RAM word in while a fetch is pending
  assign eff     = pend ? (ram_q + acc) : acc;
  assign same    = have && (bin == cur_bin);
  assign wr_en   = (take && have && !same) || (flush && have);
  assign wr_addr = cur_bin;
  assign wr_data = eff;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cur_bin <= '0;
      acc     <= '0;
      pend    <= 1'b0;
      have    <= 1'b0;
    end else if (take) begin
      if (same) begin
        acc  <= eff + 1'b1;
        pend <= 1'b0;
      end else begin
        cur_bin <= bin;
        acc     <= CW'(1);
        pend    <= 1'b1;
        have    <= 1'b1;
      end
    end else begin
      if (pend) begin
        acc  <= eff;
        pend <= 1'b0;
      end
      if (flush) have <= 1'b0;
    end
  end

  // R4: a repeated bin with a settled count steps it by exactly one
  a_r4_run_increment: assert property (@(posedge clk) disable iff (rst || restart)
    (take && have && bin == cur_bin && !pend) |=> (acc == $past(acc) + 1'b1));
endmodule

// File: rtl/hist_accum.sv
module hist_accum
  import hist_pkg::*;
#(
  parameter int NBINS  = 256,
  parameter int CNT_W  = 16,
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BIN_W-1:0] in_bin,
  input  logic             in_last,
  output logic             done,
  input  logic [BIN_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  hist_state_t      state;
  logic             clr_we, flush, take;
  logic [BIN_W-1:0] clr_addr;
  logic             acc_we;
  logic [BIN_W-1:0] acc_waddr;
  logic [CNT_W-1:0] acc_wdata;
  logic             ram_we;
  logic [BIN_W-1:0] ram_waddr, ram_raddr;
  logic [CNT_W-1:0] ram_wdata, ram_q;

  assign take = in_valid && in_ready;

  hist_seq #(.NBINS(NBINS)) u_seq (
    .clk(clk), .rst(rst), .clr_start(clr_start), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .clr_we(clr_we),
    .clr_addr(clr_addr), .flush(flush), .done(done), .state(state)
  );

  hist_acc #(.AW(BIN_W), .CW(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .restart(clr_start), .take(take), .bin(in_bin),
    .flush(flush), .ram_q(ram_q), .wr_en(acc_we), .wr_addr(acc_waddr),
    .wr_data(acc_wdata)
  );

  always_comb begin
    if (clr_we) begin
      ram_we    = 1'b1;
      ram_waddr = clr_addr;
      ram_wdata = '0;
    end else begin
      ram_we    = acc_we;
      ram_waddr = acc_waddr;
      ram_wdata = acc_wdata;
    end
    ram_raddr = (state == ST_RUN) ? in_bin : rd_addr;
  end

  hist_ram #(.DEPTH(NBINS), .W(CNT_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  assign rd_data = ram_q;

  // R5: write-back and fetch never hit the same counter
  a_r5_ports_apart: assert property (@(posedge clk) disable iff (rst)
    (take && ram_we) |-> (ram_waddr != ram_raddr));
  // R4: back-to-back samples of one bin leave the RAM untouched
  a_r4_run_no_write: assert property (@(posedge clk) disable iff (rst)
    (take && $past(take) && in_bin == $past(in_bin) && !$past(clr_start)) |-> !ram_we);
endmodule

// File: tb/sim_hist_accum.sv
module sim_hist_accum;
  localparam int CLK_P = 10;
  localparam int NB    = 16;
  localparam int CW    = 4;
  localparam int BW    = $clog2(NB);
  localparam int NS    = 24;
  localparam logic [BW-1:0] STIM [NS] = '{
    4'd3, 4'd3, 4'd3, 4'd7, 4'd2, 4'd7, 4'd2, 4'd7, 4'd9, 4'd9, 4'd1, 4'd9,
    4'd15, 4'd0, 4'd0, 4'd0, 4'd0, 4'd4, 4'd4, 4'd5, 4'd4, 4'd12, 4'd12, 4'd3};

  logic clk = 0, rst = 1, clr_start = 0, in_valid = 0, in_last = 0;
  logic [BW-1:0] in_bin = '0, rd_addr = '0;
  logic in_ready, done;
  logic [CW-1:0] rd_data;
  int errors = 0, checks = 0;
  int expc [NB];

  always #(CLK_P/2) clk = ~clk;

  hist_accum #(.NBINS(NB), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .clr_start(clr_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_bin(in_bin), .in_last(in_last), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_frame();
    int n = 0;
    @(negedge clk) clr_start = 1;
    @(posedge clk);
    @(negedge clk) clr_start = 0;
    while (!in_ready && n < 4*NB) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    chk("R2 clear length", n, NB);
    for (int i = 0; i < NB; i++) expc[i] = 0;
  endtask

  task automatic send(logic [BW-1:0] b, logic last);
    @(negedge clk);
    chk("R6 ready per sample", int'(in_ready), 1);
    in_valid = 1; in_bin = b; in_last = last;
    expc[b] = (expc[b] + 1) % (1 << CW);
    @(posedge clk);
  endtask

  task automatic gap();
    @(negedge clk) in_valid = 0;
    @(posedge clk);
  endtask

  task automatic end_frame();
    @(negedge clk) in_valid = 0; in_last = 0;
    chk("R9 done not early", int'(done), 0);
    @(negedge clk) chk("R9 done pulse", int'(done), 1);
    @(negedge clk) chk("R9 done one cycle", int'(done), 0);
  endtask

  task automatic read_bin(int a, output int v);
    @(negedge clk) rd_addr = BW'(a);
    @(posedge clk);
    @(negedge clk) v = int'(rd_data);
  endtask

  task automatic check_all(string req);
    int v;
    for (int i = 0; i < NB; i++) begin
      read_bin(i, v);
      chk(req, v, expc[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", int'(in_ready), 0);
    chk("R1 done in reset", int'(done), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 ready after reset", int'(in_ready), 0);
    chk("R1 done after reset", int'(done), 0);

    // R2 R11: cleared counters read back as zero
    open_frame();
    @(negedge clk);
    chk("R6 ready before first sample", int'(in_ready), 1);
    // close an empty-looking frame by sending the table
    // R3 R4 R7 R8: table of bins walked back to back
    for (int k = 0; k < NS; k++) send(STIM[k], k == NS-1);
    end_frame();
    check_all("R3 R4 R7 R8 R11 table counts");

    // R10 R8: wrap-around plus idle gaps after a fetch
    open_frame();
    send(4'd10, 0);
    gap();
    gap();
    send(4'd10, 0);
    for (int k = 0; k < 17; k++) begin
      send(4'd5, 0);
      if (k == 8) gap();
    end
    send(4'd6, 0);
    send(4'd6, 1);
    end_frame();
    read_bin(5, v);  chk("R10 wrap", v, 1);
    read_bin(10, v); chk("R8 gap after fetch", v, 2);
    read_bin(6, v);  chk("R3 last pair", v, 2);
    check_all("R3 frame two counts");

    // R12: samples offered while idle change nothing
    @(negedge clk) in_valid = 1; in_bin = 4'd10;
    chk("R12 ready low when idle", int'(in_ready), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) in_valid = 0;
    read_bin(10, v); chk("R12 idle sample ignored", v, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule